// File: doc/BRIEF.md
# Audio Serial Bit Clock Generator

This block produces the serial bit clock for an audio receiver and tells the neighbouring shift logic when to act. The clock can be built internally from one of four master clock sources. Each source is presented as a one-cycle tick strobe in the system clock domain, and an even programmable divider turns the ticks into a clock with a 50% duty cycle. The clock can also be taken from one of two external bit clock inputs, which are already synchronised to the system clock. Two one-cycle strobes come out with the clock. `drive_stb` marks the edge on which serial outputs must change, and `sample_stb` marks the edge on which serial inputs must be captured. A polarity bit decides which pin edge is which.

Configuration arrives as one 32-bit word. The block latches it when it is enabled, and after that only at the end of a bit clock period. A new divide ratio, source or mode therefore never shortens a half period in progress. The control is a four-state machine:

- `ST_IDLE`: disabled. The clock rests at its inactive level.
- `ST_LOW`: internal clock, inactive half.
- `ST_HIGH`: internal clock, active half.
- `ST_SLAVE`: external clock followed.

The transitions are:

- `ST_IDLE` to `ST_LOW` or `ST_SLAVE` when enabled (this is the load).
- `ST_LOW` to `ST_HIGH` at the divider terminal count (this is the drive edge).
- `ST_HIGH` to `ST_LOW` or `ST_SLAVE` at the terminal count (the sample edge, which is also the period boundary and reloads the configuration).
- `ST_SLAVE` to `ST_LOW` or `ST_SLAVE` at each external sample edge (a period boundary, with reload).
- Any state to `ST_IDLE` when enable is low.

Top module: `audio_bclk_gen`

## Requirements
- R1: In internal mode the bit clock period is 2*(div+1) ticks of the selected source, where div is cfg_word bits 7:0. This covers ratios from 2 to 512.
- R2: The source select in cfg_word bits 27:26 picks tick input mclk_tick[sel]. Value 0 is the bus clock tick and values 1 to 3 are master clock options 1 to 3.
- R3: In internal mode, drive_stb and the following sample_stb are (div+1) source ticks apart, which gives a 50% duty cycle.
- R4: Polarity is cfg_word bit 25. With 0, drive_stb comes with the rising edge of bclk_out and sample_stb with the falling edge. With 1, the edges are swapped. When idle, bclk_out rests at the polarity value.
- R5: Direction is cfg_word bit 24. With 1 the clock is generated internally. With 0, bclk_out follows the selected external input one cycle later, the strobes mark that input's edges in the same cycle, and div and source select have no effect.
- R6: Swap is cfg_word bit 29. In external mode, swap 0 follows ext_bclk_a and swap 1 follows ext_bclk_b. The unselected input has no effect.
- R7: Clock-as-input is cfg_word bit 28. In internal mode, a 1 derives the strobes from the generated pin clock as if it were external, one cycle after each bclk_out edge. In external mode it has no effect.
- R8: cfg_word bits 23:8 are reserved and have no effect.
- R9: A new configuration takes effect only at a period boundary (the sample edge). The active half in progress keeps its length.
- R10: Reset clears bclk_out and both strobes. One cycle after enable is low, bclk_out equals the polarity and both strobes are low. drive_stb and sample_stb are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low returns to idle |
| cfg_word | input | 32 | Configuration word |
| mclk_tick | input | 4 | One-cycle tick per master clock source |
| ext_bclk_a | input | 1 | Normal external bit clock (synchronised) |
| ext_bclk_b | input | 1 | Alternate external bit clock (synchronised) |
| bclk_out | output | 1 | Bit clock level |
| drive_stb | output | 1 | Output-change edge strobe |
| sample_stb | output | 1 | Input-capture edge strobe |

## Verification
The hardest situation to bring about from the ports is a configuration change that lands in the middle of an active half period, because the write has to arrive at a known phase of the divider. The bench waits for `drive_stb`, which marks the start of the active half, and rewrites the divide field in that same cycle. It then counts how many cycles `bclk_out` stays high and how many it stays low: the high half must keep the old length and the next low half must take the new one. In external mode the bench toggles the unselected input on its own between edges of the selected one, to show that it is ignored.

// File: rtl/abg_pkg.sv
package abg_pkg;
    localparam int CFG_W    = 32;
    localparam int DIV_W    = 8;
    localparam int SEL_W    = 2;
    localparam int N_SRC    = 1 << SEL_W;
    localparam int DIV_LSB  = 0;
    localparam int DIR_BIT  = 24;
    localparam int POL_BIT  = 25;
    localparam int SEL_LSB  = 26;
    localparam int BCI_BIT  = 28;
    localparam int SWAP_BIT = 29;
    localparam int RSV_LSB  = 8;
    localparam int RSV_MSB  = 23;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_SLAVE = 2'd3
    } abg_state_e;

    typedef struct packed {
        logic             swap;
        logic             bci;
        logic [SEL_W-1:0] sel;
        logic             pol;
        logic             dir;
        logic [DIV_W-1:0] div;
    } abg_cfg_t;
endpackage

// File: rtl/abg_cfg_unpack.sv
module abg_cfg_unpack
    import abg_pkg::*;
(
    input  logic [CFG_W-1:0] word,
    output abg_cfg_t         cfg
);
    // Reserved and spare bits are decoded into nothing.
    logic unused_bits;
    assign unused_bits = ^{word[RSV_MSB:RSV_LSB], word[CFG_W-1:SWAP_BIT+1]};

    always_comb begin
        cfg.div  = word[DIV_LSB +: DIV_W];
        cfg.dir  = word[DIR_BIT];
        cfg.pol  = word[POL_BIT];
        cfg.sel  = word[SEL_LSB +: SEL_W];
        cfg.bci  = word[BCI_BIT];
        cfg.swap = word[SWAP_BIT];
    end
endmodule

// File: rtl/abg_divider.sv
module abg_divider #(
    parameter int NSRC = 4,
    parameter int SELW = 2,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [NSRC-1:0] tick_vec,
    input  logic [SELW-1:0] sel,
    input  logic [DIVW-1:0] limit,
    output logic            term
);
    logic [NSRC-1:0] pick;
    logic            tick;
    logic [DIVW-1:0] cnt;

    // One-hot AND-OR source selector, one leg per source.
    for (genvar g = 0; g < NSRC; g++) begin : g_pick
        assign pick[g] = tick_vec[g] && (sel == SELW'(g));
    end
    assign tick = |pick;
    assign term = tick && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= term ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/abg_edge_sense.sv
module abg_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic mask,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= level;
        end
    end

    assign rise = !mask && level && !prev;
    assign fall = !mask && !level && prev;
endmodule

// File: rtl/audio_bclk_gen.sv
module audio_bclk_gen
    import abg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [N_SRC-1:0] mclk_tick,
    input  logic             ext_bclk_a,
    input  logic             ext_bclk_b,
    output logic             bclk_out,
    output logic             drive_stb,
    output logic             sample_stb
);
    abg_state_e state, nxt;
    abg_cfg_t   cfg_dec, cfg_l, cfg_eff;
    logic       term, load, div_clr;
    logic       ext_now, ext_eff, ed_level, ed_mask;
    logic       e_rise, e_fall, ed_drive, ed_sample;
    logic       nat_drive, nat_sample, use_ed, slv_bound, in_master;
    logic [1:0] srcid, srcid_q;

    abg_cfg_unpack u_unpack (
        .word (cfg_word),
        .cfg  (cfg_dec)
    );

    assign in_master = (state == ST_LOW) || (state == ST_HIGH);
    assign div_clr   = !in_master;

    abg_divider #(.NSRC(N_SRC), .SELW(SEL_W), .DIVW(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (div_clr),
        .tick_vec (mclk_tick),
        .sel      (cfg_l.sel),
        .limit    (cfg_l.div),
        .term     (term)
    );

    // Edge sensing for the external clock, or for the pin clock when it is
    // treated as an input; masked for one cycle whenever its source moves.
    assign ext_now  = cfg_l.swap ? ext_bclk_b : ext_bclk_a;
    assign ed_level = (state == ST_SLAVE) ? ext_now : bclk_out;
    assign srcid    = {state == ST_SLAVE, (state == ST_SLAVE) && cfg_l.swap};
    assign ed_mask  = (state == ST_IDLE) || (srcid != srcid_q);

    abg_edge_sense u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ed_level),
        .mask  (ed_mask),
        .rise  (e_rise),
        .fall  (e_fall)
    );

    assign ed_drive   = cfg_l.pol ? e_fall : e_rise;
    assign ed_sample  = cfg_l.pol ? e_rise : e_fall;
    assign nat_drive  = (state == ST_LOW)  && term;
    assign nat_sample = (state == ST_HIGH) && term;
    assign slv_bound  = (state == ST_SLAVE) && ed_sample;
    assign use_ed     = (state == ST_SLAVE) || (in_master && cfg_l.bci);

    // Next-state logic.
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (enable) begin
                    load = 1'b1;
                    nxt  = cfg_dec.dir ? ST_LOW : ST_SLAVE;
                end
            end
            ST_LOW: begin
                if (!enable)   nxt = ST_IDLE;
                else if (term) nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (!enable) begin
                    nxt = ST_IDLE;
                end else if (term) begin
                    load = 1'b1;
                    nxt  = cfg_dec.dir ? ST_LOW : ST_SLAVE;
                end
            end
            ST_SLAVE: begin
                if (!enable) begin
                    nxt = ST_IDLE;
                end else if (slv_bound) begin
                    load = 1'b1;
                    nxt  = cfg_dec.dir ? ST_LOW : ST_SLAVE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign cfg_eff = load ? cfg_dec : cfg_l;
    assign ext_eff = cfg_eff.swap ? ext_bclk_b : ext_bclk_a;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            srcid_q <= 2'b00;
        end else begin
            state   <= nxt;
            srcid_q <= srcid;
        end
    end

    // Configuration is held between period boundaries.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_l <= '0;
        end else if (load) begin
            cfg_l <= cfg_dec;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_out   <= 1'b0;
            drive_stb  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            unique case (nxt)
                ST_IDLE: begin
                    bclk_out   <= cfg_dec.pol;
                    drive_stb  <= 1'b0;
                    sample_stb <= 1'b0;
                end
                ST_LOW, ST_HIGH: begin
                    bclk_out   <= (nxt == ST_HIGH) ^ cfg_eff.pol;
                    drive_stb  <= use_ed ? ed_drive  : nat_drive;
                    sample_stb <= use_ed ? ed_sample : nat_sample;
                end
                ST_SLAVE: begin
                    bclk_out   <= ext_eff;
                    drive_stb  <= use_ed ? ed_drive  : nat_drive;
                    sample_stb <= use_ed ? ed_sample : nat_sample;
                end
                default: begin
                    bclk_out   <= cfg_dec.pol;
                    drive_stb  <= 1'b0;
                    sample_stb <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/abg_checker.sv
module abg_checker
    import abg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [CFG_W-1:0] cfg_word,
    input logic             bclk_out,
    input logic             drive_stb,
    input logic             sample_stb,
    input abg_state_e       state,
    input logic [DIV_W-1:0] div_l,
    input logic             pol_l,
    input logic             bci_l
);
    localparam int RUN_W = 16;
    logic             b_q;
    logic [RUN_W-1:0] run;
    logic             mst_now;

    assign mst_now = (state == ST_LOW) || (state == ST_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= 1'b0;
            run <= '0;
        end else begin
            b_q <= bclk_out;
            if (bclk_out != b_q)   run <= RUN_W'(1);
            else if (run != '1)    run <= run + 1'b1;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_stb && sample_stb)); // R10

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!drive_stb && !sample_stb)); // R10

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (bclk_out == $past(cfg_word[POL_BIT]))); // R4

    AST_DRIVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_stb && state == ST_HIGH && !bci_l) |-> (bclk_out != pol_l)); // R4

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_out != b_q && mst_now && ($past(state) == ST_LOW || $past(state) == ST_HIGH))
        |-> (run >= RUN_W'($past(div_l)) + RUN_W'(1))); // R9
endmodule

bind audio_bclk_gen abg_checker u_abg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_word   (cfg_word),
    .bclk_out   (bclk_out),
    .drive_stb  (drive_stb),
    .sample_stb (sample_stb),
    .state      (state),
    .div_l      (cfg_l.div),
    .pol_l      (cfg_l.pol),
    .bci_l      (cfg_l.bci)
);

// File: tb/tb_audio_bclk_gen.sv
module tb_audio_bclk_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [31:0] cfg_word;
    logic [3:0]  mclk_tick;
    logic        ext_bclk_a, ext_bclk_b;
    logic        bclk_out, drive_stb, sample_stb;
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    int          tcnt [4];

    always #2 clk = ~clk;

    audio_bclk_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_word   (cfg_word),
        .mclk_tick  (mclk_tick),
        .ext_bclk_a (ext_bclk_a),
        .ext_bclk_b (ext_bclk_b),
        .bclk_out   (bclk_out),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );

    function automatic int rate_of(int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 3 : 5;
    endfunction

    function automatic logic [31:0] mk(int pol, int sel, int div, int dir,
                                       int bci, int swp, int resv);
        logic [31:0] w = '0;
        w[7:0]   = div[7:0];
        w[24]    = dir[0];
        w[25]    = pol[0];
        w[27:26] = sel[1:0];
        w[28]    = bci[0];
        w[29]    = swp[0];
        if (resv != 0) w[23:8] = 16'hFFFF;
        return w;
    endfunction

    // Tick generators: source k pulses once every rate_of(k) cycles.
    initial begin
        mclk_tick = '0;
        for (int k = 0; k < 4; k++) tcnt[k] = 0;
    end
    always @(negedge clk) begin
        cyc++;
        for (int k = 0; k < 4; k++) begin
            mclk_tick[k] = (tcnt[k] == 0);
            tcnt[k] = (tcnt[k] + 1) % rate_of(k);
        end
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_master(int pol, int sel, int div, int bci, int resv);
        int  nd = 0;
        int  last_d = 0;
        int  t = 0;
        int  r = rate_of(sel);
        int  per = 2 * (div + 1) * r;
        bit  pb1 = pol[0];
        bit  pb2 = pol[0];
        enable = 1'b0;
        @(negedge clk);
        cfg_word = mk(pol, sel, div, 1, bci, 0, resv);
        @(negedge clk);
        @(negedge clk);
        check(bclk_out == pol[0], "R4 idle level", int'(bclk_out), pol);
        enable = 1'b1;
        while (nd < 3 && t < 4000) begin
            @(negedge clk);
            t++;
            if (drive_stb) begin
                if (bci == 0)
                    check(bclk_out == !pol[0] && pb1 == pol[0], "R4 drive on active edge",
                          int'(bclk_out), 1 - pol);
                else
                    check(pb1 == !pol[0] && pb2 == pol[0], "R7 drive one cycle after edge",
                          int'(pb1), 1 - pol);
                if (nd > 0)
                    check(t - last_d == per, (resv != 0) ? "R8 period with reserved bits set"
                          : "R1 R2 period", t - last_d, per);
                last_d = t;
                nd++;
            end
            if (sample_stb && nd > 0) begin
                check(t - last_d == (div + 1) * r, "R3 drive to sample spacing",
                      t - last_d, (div + 1) * r);
                if (bci == 0)
                    check(bclk_out == pol[0], "R4 sample on inactive edge", int'(bclk_out), pol);
            end
            pb2 = pb1;
            pb1 = bclk_out;
        end
        check(nd == 3, "R1 drive strobes present", nd, 3);
        enable = 1'b0;
        @(negedge clk);
        check(bclk_out == pol[0] && !drive_stb && !sample_stb, "R10 disable to idle",
              int'(bclk_out), pol);
    endtask

    task automatic set_ext(int swp, bit v_sel, bit v_oth);
        if (swp != 0) begin ext_bclk_b = v_sel; ext_bclk_a = v_oth; end
        else          begin ext_bclk_a = v_sel; ext_bclk_b = v_oth; end
    endtask

    task automatic run_slave(int pol, int swp, int bci);
        enable = 1'b0;
        set_ext(swp, 1'b0, 1'b0);
        @(negedge clk);
        cfg_word = mk(pol, 3, 200, 0, bci, swp, 0);
        @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check(bclk_out == 1'b0 && !drive_stb && !sample_stb, "R5 slave quiet start",
              int'(bclk_out), 0);
        for (int i = 0; i < 2; i++) begin
            set_ext(swp, 1'b1, 1'b0);
            @(negedge clk);
            check(bclk_out && drive_stb == (pol == 0) && sample_stb == (pol == 1),
                  (bci != 0) ? "R7 no effect in slave, rise" : "R5 slave rise edge",
                  {drive_stb, sample_stb}, (pol == 0) ? 2 : 1);
            set_ext(swp, 1'b1, 1'b1);
            @(negedge clk);
            check(bclk_out && !drive_stb && !sample_stb, "R6 unselected input ignored",
                  {bclk_out, drive_stb, sample_stb}, 4);
            set_ext(swp, 1'b0, 1'b1);
            @(negedge clk);
            check(!bclk_out && drive_stb == (pol == 1) && sample_stb == (pol == 0),
                  "R5 slave fall edge", {drive_stb, sample_stb}, (pol == 1) ? 2 : 1);
            set_ext(swp, 1'b0, 1'b0);
            @(negedge clk);
            check(!bclk_out && !drive_stb && !sample_stb, "R6 unselected input ignored low",
                  {bclk_out, drive_stb, sample_stb}, 0);
        end
        enable = 1'b0;
        @(negedge clk);
        check(bclk_out == pol[0] && !drive_stb && !sample_stb, "R10 slave disable",
              int'(bclk_out), pol);
    endtask

    task automatic run_reconfig();
        int hi = 1;
        int lo = 1;
        int hi2 = 1;
        int t = 0;
        enable = 1'b0;
        @(negedge clk);
        cfg_word = mk(0, 0, 3, 1, 0, 0, 0);
        @(negedge clk);
        enable = 1'b1;
        while (!drive_stb && t < 200) begin @(negedge clk); t++; end
        cfg_word = mk(0, 0, 1, 1, 0, 0, 0);
        @(negedge clk);
        while (bclk_out && hi < 100) begin hi++; @(negedge clk); end
        @(negedge clk);
        while (!bclk_out && lo < 100) begin lo++; @(negedge clk); end
        @(negedge clk);
        while (bclk_out && hi2 < 100) begin hi2++; @(negedge clk); end
        check(hi == 4, "R9 active half keeps old length", hi, 4);
        check(lo == 2, "R9 new divide after boundary", lo, 2);
        check(hi2 == 2, "R9 new divide active half", hi2, 2);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n      = 1'b0;
        enable     = 1'b0;
        cfg_word   = '0;
        ext_bclk_a = 1'b0;
        ext_bclk_b = 1'b0;
        repeat (3) @(negedge clk);
        check(!bclk_out && !drive_stb && !sample_stb, "R10 reset state",
              {bclk_out, drive_stb, sample_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 3; d++)
                    run_master(p, s, (d == 0) ? 0 : (d == 1) ? 2 : 5, 0, 0);
        run_master(0, 2, 4, 0, 1);
        run_master(1, 1, 3, 0, 1);
        run_master(0, 1, 1, 1, 0);
        run_master(1, 0, 2, 1, 0);
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++)
                for (int b = 0; b < 2; b++)
                    run_slave(p, w, b);
        run_reconfig();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule